// File: doc/BRIEF.md
# Dual-Clock FIFO with Fall-Through Read Mode

This block is a 36-bit first-in first-out buffer. A producer writes on one clock and a consumer reads on another. The two clocks may be unrelated or may be the same clock. Each side moves a word only on a rising edge of its own clock while its own enable is high. The write and read pointers cross between the domains as Gray code through two-flop synchronisers. Every flag is computed from the local pointer and the synchronised far pointer. As a result, a full or empty condition is never reported late, and clearing either one may take a few cycles.

The read behaviour is picked during master reset. In standard mode, a stored word stays in memory until a read fetches it. The two boundary flags then mean empty and full. In fall-through mode, the oldest word moves into an output stage by itself. The read-side flag then means "valid word on the output", and the write-side flag means "room for another word". Also during reset, a two-bit select either gives both almost flags a fixed offset or requests that the offsets be loaded through the write data bus. The configuration pins are ignored after reset.

Top module: `xfifo_top`

## Requirements
- R1: While master reset `rst_n` is low, both pointers return to the first location and `rd_data` is cleared. After release, with no traffic: in standard mode `out_flag`=1 and `in_flag`=0; in fall-through mode `out_flag`=0 and `in_flag`=1. In both modes `almost_empty`=1 and `almost_full`=0.
- R2: `cfg_offset_sel`, sampled during reset, sets both almost offsets: 2'b01 gives 8 words, 2'b10 gives 16 and 2'b11 gives 64. 2'b00 selects parallel loading.
- R3: With parallel loading, the first two writes after reset are not stored. The first sets the almost-empty offset from `wr_data[ADDR_W:0]` and the second sets the almost-full offset from the same field. The first word read is the third word written.
- R4: In standard mode, words leave in write order. A read accepted at a `rd_clk` edge puts the word on `rd_data` at that edge, and `rd_data` otherwise holds its value. `out_flag` is 1 exactly when no word is stored.
- R5: In fall-through mode, the first word written to an empty FIFO appears on `rd_data` with `out_flag`=1 and no read. Each read while `out_flag`=1 replaces it with the next word, or clears `out_flag` if none is left. Without a read, `rd_data` holds.
- R6: The write-side flag reports full storage: `in_flag`=1 (standard) or `in_flag`=0 (fall-through) once 2^ADDR_W words sit in the memory. In fall-through mode the output stage holds one more word.
- R7: A write while full (or not input-ready) is ignored, and its word never appears at the output.
- R8: A read while empty (or not output-ready) is ignored: `rd_data` and the pointers are unchanged.
- R9: `almost_empty` is 1 exactly when the stored word count is at or below the almost-empty offset. In fall-through mode the count includes the word in the output stage.
- R10: `almost_full` is 1 exactly when the free memory space (2^ADDR_W minus the words in memory) is at or below the almost-full offset.
- R11: A flag that blocks a port asserts on the very edge that causes it. With both ports on one clock, `out_flag` reports a new word on the third `rd_clk` edge after the write, or at the fourth edge for the fall-through output. A full flag clears on the third `wr_clk` edge after a read.
- R12: `cfg_fall_through` and `cfg_offset_sel` have no effect once reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Master reset, active low, asynchronous assert |
| cfg_fall_through | input | 1 | Read mode sampled in reset: 1 = fall-through, 0 = standard |
| cfg_offset_sel | input | 2 | Almost-offset choice sampled in reset |
| wr_en | input | 1 | Write enable |
| wr_data | input | DATA_W | Write data, also the offset load bus |
| in_flag | output | 1 | Full (standard) or input-ready (fall-through), write clock domain |
| almost_full | output | 1 | Almost-full flag, write clock domain |
| rd_en | input | 1 | Read enable |
| rd_data | output | DATA_W | Read data |
| out_flag | output | 1 | Empty (standard) or output-ready (fall-through), read clock domain |
| almost_empty | output | 1 | Almost-empty flag, read clock domain |

## Verification
The bench builds the block with ADDR_W=7, which gives a 128-word memory. At this depth the full boundary, the almost-full boundary and a write refused while full can all be reached in a few hundred cycles. All three fixed offsets (8, 16 and 64) stay below the depth, so each one produces a real transition in both almost flags. Both ports share one clock, so the synchroniser delay is a known number of edges, and the bench checks both the cycle before a flag clears and the cycle in which it clears. A 16-entry stimulus table exercises standard mode around the 8-word almost-empty edge. Directed runs then cover fall-through mode, parallel loading, reset state and ignored configuration changes.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;

  typedef enum logic [1:0] {
    OFS_PROG = 2'b00,
    OFS_8    = 2'b01,
    OFS_16   = 2'b10,
    OFS_64   = 2'b11
  } ofs_sel_e;

  typedef enum logic [1:0] {
    LD_AE  = 2'd0,
    LD_AF  = 2'd1,
    LD_RUN = 2'd2
  } ld_state_e;

  localparam int OFS_SMALL  = 8;
  localparam int OFS_MEDIUM = 16;
  localparam int OFS_LARGE  = 64;

endpackage

// File: rtl/xfifo_rst_sync.sv
module xfifo_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES == 1) begin : g_one
      assign sh_d = 1'b1;
    end else begin : g_many
      assign sh_d = {sh_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rst_n_o = sh_q[STAGES-1];

endmodule

// File: rtl/xfifo_ptr_sync.sv
module xfifo_ptr_sync #(
  parameter int W      = 11,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= gray_in;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  generate
    for (genvar g = 0; g < W; g++) begin : g_g2b
      assign bin_out[g] = ^(stg_q[STAGES-1] >> g);
    end
  endgenerate

endmodule

// File: rtl/xfifo_mem.sv
module xfifo_mem #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
  end

  assign rdata = ram[raddr];

endmodule

// File: rtl/xfifo_wr_ctl.sv
module xfifo_wr_ctl
  import xfifo_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_ft,
  input  logic [1:0]        cfg_sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W:0]   rd_bin_sync,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [ADDR_W:0]   wr_bin,
  output logic [ADDR_W:0]   wr_gray,
  output logic [ADDR_W:0]   ae_off,
  output logic              full,
  output logic              almost_full,
  output logic              in_flag
);

  localparam int CNT_W = ADDR_W + 1;
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(1) << ADDR_W;

  logic             mode_q;
  ld_state_e        ld_q, ld_d;
  logic [CNT_W-1:0] ae_q, af_q, dflt;
  logic [CNT_W-1:0] bin_q, bin_d, gray_q, gray_d;
  logic [CNT_W-1:0] used, free;
  logic             ld_ae, ld_af, wr_ok;

  // Offset chosen at reset time
  always_comb begin
    unique case (ofs_sel_e'(cfg_sel))
      OFS_8:   dflt = CNT_W'(OFS_SMALL);
      OFS_16:  dflt = CNT_W'(OFS_MEDIUM);
      OFS_64:  dflt = CNT_W'(OFS_LARGE);
      default: dflt = '0;
    endcase
  end

  assign used  = bin_q - rd_bin_sync;
  assign full  = (used == DEPTH_C);
  assign free  = DEPTH_C - used;
  assign ld_ae = rst_n && wr_en && (ld_q == LD_AE);
  assign ld_af = rst_n && wr_en && (ld_q == LD_AF);
  assign wr_ok = rst_n && wr_en && (ld_q == LD_RUN) && !full;

  always_comb begin
    ld_d = ld_q;
    if (ld_ae)      ld_d = LD_AF;
    else if (ld_af) ld_d = LD_RUN;
    bin_d  = wr_ok ? bin_q + CNT_W'(1) : bin_q;
    gray_d = bin_d ^ (bin_d >> 1);
  end

  // Configuration: captured while the domain is held in reset
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= cfg_ft;
      ae_q   <= dflt;
      af_q   <= dflt;
      ld_q   <= (ofs_sel_e'(cfg_sel) == OFS_PROG) ? LD_AE : LD_RUN;
    end else begin
      ld_q <= ld_d;
      if (ld_ae) ae_q <= wr_data[CNT_W-1:0];
      if (ld_af) af_q <= wr_data[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_d;
      gray_q <= gray_d;
    end
  end

  assign mem_we      = wr_ok;
  assign mem_waddr   = bin_q[ADDR_W-1:0];
  assign wr_bin      = bin_q;
  assign wr_gray     = gray_q;
  assign ae_off      = ae_q;
  assign almost_full = (free <= af_q);
  assign in_flag     = mode_q ? !full : full;

endmodule

// File: rtl/xfifo_rd_ctl.sv
module xfifo_rd_ctl #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_ft,
  input  logic              rd_en,
  input  logic [ADDR_W:0]   wr_bin_sync,
  input  logic [ADDR_W:0]   ae_off,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_raddr,
  output logic [ADDR_W:0]   rd_bin,
  output logic [ADDR_W:0]   rd_gray,
  output logic              mode,
  output logic [DATA_W-1:0] rd_data,
  output logic              out_flag,
  output logic              almost_empty
);

  localparam int CNT_W = ADDR_W + 1;

  logic              mode_q;
  logic [CNT_W-1:0]  bin_q, bin_d, gray_q, gray_d;
  logic [CNT_W-1:0]  mem_cnt, occ;
  logic              mem_has, pop;
  logic              ov_q, ov_d;
  logic [DATA_W-1:0] dout_q, dout_d;

  assign mem_cnt = wr_bin_sync - bin_q;
  assign mem_has = (mem_cnt != '0);

  always_comb begin
    if (mode_q) begin
      pop  = mem_has && (!ov_q || rd_en);
      ov_d = pop ? 1'b1 : (rd_en ? 1'b0 : ov_q);
    end else begin
      pop  = rd_en && mem_has;
      ov_d = 1'b0;
    end
    dout_d = pop ? mem_rdata : dout_q;
    bin_d  = pop ? bin_q + CNT_W'(1) : bin_q;
    gray_d = bin_d ^ (bin_d >> 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= cfg_ft;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
      ov_q   <= 1'b0;
      dout_q <= '0;
    end else begin
      bin_q  <= bin_d;
      gray_q <= gray_d;
      ov_q   <= ov_d;
      dout_q <= dout_d;
    end
  end

  assign occ          = mem_cnt + {{(CNT_W-1){1'b0}}, (mode_q & ov_q)};
  assign almost_empty = (occ <= ae_off);
  assign out_flag     = mode_q ? ov_q : !mem_has;
  assign mem_raddr    = bin_q[ADDR_W-1:0];
  assign rd_bin       = bin_q;
  assign rd_gray      = gray_q;
  assign mode         = mode_q;
  assign rd_data      = dout_q;

endmodule

// File: rtl/xfifo_top.sv
module xfifo_top #(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              cfg_fall_through,
  input  logic [1:0]        cfg_offset_sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              in_flag,
  output logic              almost_full,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              out_flag,
  output logic              almost_empty
);

  localparam int CNT_W = ADDR_W + 1;

  logic              wr_rst_s, rd_rst_s;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr, mem_raddr;
  logic [DATA_W-1:0] mem_rdata;
  logic [CNT_W-1:0]  wr_bin, wr_gray, rd_bin, rd_gray;
  logic [CNT_W-1:0]  wr_bin_at_rd, rd_bin_at_wr, ae_off;
  logic              wr_full, rd_mode;

  xfifo_rst_sync #(.STAGES(SYNC_STAGES)) u_wr_rst (
    .clk(wr_clk), .arst_n(rst_n), .rst_n_o(wr_rst_s));

  xfifo_rst_sync #(.STAGES(SYNC_STAGES)) u_rd_rst (
    .clk(rd_clk), .arst_n(rst_n), .rst_n_o(rd_rst_s));

  xfifo_wr_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_s), .cfg_ft(cfg_fall_through),
    .cfg_sel(cfg_offset_sel), .wr_en(wr_en), .wr_data(wr_data),
    .rd_bin_sync(rd_bin_at_wr), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .wr_bin(wr_bin), .wr_gray(wr_gray), .ae_off(ae_off), .full(wr_full),
    .almost_full(almost_full), .in_flag(in_flag));

  xfifo_ptr_sync #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rd_clk), .rst_n(rd_rst_s), .gray_in(wr_gray), .bin_out(wr_bin_at_rd));

  xfifo_ptr_sync #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wr_clk), .rst_n(wr_rst_s), .gray_in(rd_gray), .bin_out(rd_bin_at_wr));

  xfifo_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(wr_clk), .we(mem_we), .waddr(mem_waddr), .wdata(wr_data),
    .raddr(mem_raddr), .rdata(mem_rdata));

  xfifo_rd_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_s), .cfg_ft(cfg_fall_through), .rd_en(rd_en),
    .wr_bin_sync(wr_bin_at_rd), .ae_off(ae_off), .mem_rdata(mem_rdata),
    .mem_raddr(mem_raddr), .rd_bin(rd_bin), .rd_gray(rd_gray), .mode(rd_mode),
    .rd_data(rd_data), .out_flag(out_flag), .almost_empty(almost_empty));

endmodule

// File: rtl/xfifo_checks.sv
module xfifo_checks #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 36
) (
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              wr_rst_n,
  input logic              rd_rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic              wr_full,
  input logic              rd_mode,
  input logic              out_flag,
  input logic              almost_empty,
  input logic              almost_full,
  input logic [DATA_W-1:0] rd_data,
  input logic [ADDR_W:0]   wr_bin,
  input logic [ADDR_W:0]   rd_bin
);

  assert_no_overflow_R7: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_en && wr_full) |=> $stable(wr_bin));

  assert_no_underflow_std_R8: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (!rd_mode && rd_en && out_flag) |=> ($stable(rd_bin) && $stable(rd_data)));

  assert_no_underflow_ft_R8: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_mode && rd_en && !out_flag) |=> $stable(rd_data));

  assert_std_hold_R4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (!rd_mode && !rd_en) |=> $stable(rd_data));

  assert_ft_hold_R5: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_mode && out_flag && !rd_en) |=> (out_flag && $stable(rd_data)));

  assert_ft_drop_R5: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_mode && $fell(out_flag)) |-> $past(rd_en));

  assert_empty_ae_R9: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (!rd_mode && out_flag) |-> almost_empty);

  assert_full_af_R10: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_full |-> almost_full);

endmodule

bind xfifo_top xfifo_checks #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .wr_rst_n(wr_rst_s), .rd_rst_n(rd_rst_s),
  .wr_en(wr_en), .rd_en(rd_en), .wr_full(wr_full), .rd_mode(rd_mode),
  .out_flag(out_flag), .almost_empty(almost_empty), .almost_full(almost_full),
  .rd_data(rd_data), .wr_bin(wr_bin), .rd_bin(rd_bin));

// File: tb/xfifo_top_bench.sv
module xfifo_top_bench;

  localparam int AW = 7;
  localparam int DW = 36;
  localparam int DEPTH = 1 << AW;

  logic clk;
  logic rst_n;
  logic cfg_ft;
  logic [1:0] cfg_sel;
  logic wr_en, rd_en;
  logic [DW-1:0] wr_data;
  logic in_flag, almost_full, out_flag, almost_empty;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [DW-1:0] model [$];

  xfifo_top #(.ADDR_W(AW), .DATA_W(DW)) u_xfifo_top (
    .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n),
    .cfg_fall_through(cfg_ft), .cfg_offset_sel(cfg_sel),
    .wr_en(wr_en), .wr_data(wr_data), .in_flag(in_flag),
    .almost_full(almost_full), .rd_en(rd_en), .rd_data(rd_data),
    .out_flag(out_flag), .almost_empty(almost_empty));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {op, data}: op 1 = read, op 0 = write
  localparam logic [DW:0] VEC [16] = '{
    {1'b0, 36'h0_0000_0001}, {1'b0, 36'hF_FFFF_FFFE},
    {1'b0, 36'hA_5A5A_5A5A}, {1'b0, 36'h5_A5A5_A5A5},
    {1'b1, 36'h0},           {1'b0, 36'h1_2345_6789},
    {1'b0, 36'h8_0000_0000}, {1'b0, 36'h0_FFFF_0000},
    {1'b0, 36'h7_7777_7777}, {1'b0, 36'h3_C3C3_C3C3},
    {1'b0, 36'hC_0FFE_E000}, {1'b0, 36'h0_0000_0000},
    {1'b1, 36'h0},           {1'b1, 36'h0},
    {1'b0, 36'hE_DCBA_9876}, {1'b1, 36'h0}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic ft, input logic [1:0] sel);
    @(negedge clk);
    wr_en = 0; rd_en = 0; wr_data = '0;
    cfg_ft = ft; cfg_sel = sel; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_write(input logic [DW-1:0] d);
    wr_en = 1; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic do_read();
    rd_en = 1;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] exp_w;
    logic [DW-1:0] last;
    rst_n = 0; wr_en = 0; rd_en = 0; wr_data = '0; cfg_ft = 0; cfg_sel = 2'b01;

    // ---- Standard mode, 8-word offsets, table-driven ----
    do_reset(1'b0, 2'b01);
    check("R1 std reset out_flag", out_flag, 1);
    check("R1 std reset in_flag", in_flag, 0);
    check("R1 std reset almost_empty", almost_empty, 1);
    check("R1 std reset almost_full", almost_full, 0);
    check("R1 std reset rd_data", rd_data, 0);
    cfg_sel = 2'b11;  // R12: change after reset must not alter the offset
    cfg_ft  = 1'b1;   // R12: nor the mode
    for (int i = 0; i < 16; i++) begin
      if (VEC[i][DW]) begin
        exp_w = model.pop_front();
        do_read();
        check("R4 table read data", rd_data, exp_w);
      end else begin
        do_write(VEC[i][DW-1:0]);
        model.push_back(VEC[i][DW-1:0]);
      end
      settle();
      check("R9 R12 table almost_empty", almost_empty, (model.size() <= 8));
      check("R4 table out_flag", out_flag, (model.size() == 0));
    end
    while (model.size() > 0) begin
      exp_w = model.pop_front();
      do_read();
      check("R4 drain data", rd_data, exp_w);
    end

    // ---- Standard mode full boundary, 8-word offsets ----
    do_reset(1'b0, 2'b01);
    for (int i = 0; i < DEPTH; i++) begin
      do_write(36'h0_0000_0100 + 36'(i));
      if (i == DEPTH - 10) check("R10 af at free 9", almost_full, 0);
      if (i == DEPTH - 9)  check("R10 af at free 8", almost_full, 1);
      if (i == DEPTH - 2)  check("R6 not full at depth-1", in_flag, 0);
    end
    check("R6 R11 full on filling edge", in_flag, 1);
    do_write(36'hD_EAD0_0BAD);  // R7: refused
    settle();
    do_read();
    check("R4 first word", rd_data, 36'h100);
    check("R11 full still set after read edge", in_flag, 1);
    @(negedge clk);
    check("R11 full still set one edge later", in_flag, 1);
    @(negedge clk);
    check("R11 full cleared third edge", in_flag, 0);
    for (int i = 1; i < DEPTH; i++) begin
      do_read();
      check("R7 sequence after refused write", rd_data, 36'h0_0000_0100 + 36'(i));
    end
    settle();
    check("R4 empty after drain", out_flag, 1);
    last = rd_data;
    do_read();
    check("R8 read while empty holds data", rd_data, last);
    do_write(36'h0_0000_0123);
    @(negedge clk);
    check("R11 empty still set one edge after write", out_flag, 1);
    @(negedge clk);
    check("R11 empty cleared third edge", out_flag, 0);
    do_read();
    check("R8 next word after ignored read", rd_data, 36'h123);

    // ---- Standard mode, 64-word offsets ----
    do_reset(1'b0, 2'b11);
    for (int i = 0; i < 64; i++) do_write(36'(i));
    settle();
    check("R2 R9 ae at 64 with offset 64", almost_empty, 1);
    check("R2 R10 af at free 64", almost_full, 1);
    do_write(36'h40);
    settle();
    check("R2 R9 ae at 65", almost_empty, 0);

    // ---- Fall-through mode, 16-word offsets ----
    do_reset(1'b1, 2'b10);
    check("R1 ft reset out_flag", out_flag, 0);
    check("R1 ft reset in_flag", in_flag, 1);
    check("R1 ft reset almost_empty", almost_empty, 1);
    check("R1 ft reset almost_full", almost_full, 0);
    cfg_ft = 1'b0;  // R12
    do_write(36'h6_0000_0000);
    @(negedge clk);
    @(negedge clk);
    check("R11 ft not ready third edge", out_flag, 0);
    @(negedge clk);
    check("R5 R11 ft ready fourth edge", out_flag, 1);
    check("R5 R12 first word falls through", rd_data, 36'h6_0000_0000);
    do_write(36'h6_0000_0001);
    do_write(36'h6_0000_0002);
    settle();
    check("R5 ft holds without read", rd_data, 36'h6_0000_0000);
    do_read();
    check("R5 ft second word", rd_data, 36'h6_0000_0001);
    do_read();
    check("R5 ft third word", rd_data, 36'h6_0000_0002);
    do_read();
    check("R5 ft ready drops when drained", out_flag, 0);
    last = rd_data;
    do_read();
    check("R8 ft read while not ready", rd_data, last);
    for (int i = 0; i < 16; i++) do_write(36'h9_0000_0000 + 36'(i));
    settle();
    check("R2 R9 ft ae at 16 incl output word", almost_empty, 1);
    do_write(36'h9_0000_0010);
    settle();
    check("R9 ft ae at 17", almost_empty, 0);
    for (int i = 17; i < DEPTH + 1; i++) begin
      do_write(36'h9_0000_0000 + 36'(i));
      if (i == DEPTH - 1) check("R6 ft ready one short of full", in_flag, 1);
    end
    check("R6 ft not ready at full", in_flag, 0);
    check("R10 ft af at full", almost_full, 1);
    do_write(36'hB_AD00_0000);  // R7: refused
    settle();
    for (int i = 0; i < DEPTH + 1; i++) begin
      check("R7 ft sequence", rd_data, 36'h9_0000_0000 + 36'(i));
      do_read();
    end
    settle();
    check("R5 ft empty after drain", out_flag, 0);

    // ---- Parallel-loaded offsets: AE=3, AF=5 ----
    do_reset(1'b0, 2'b00);
    do_write(36'd3);
    do_write(36'd5);
    for (int i = 0; i < 3; i++) do_write(36'h4_0000_0000 + 36'(i));
    settle();
    check("R3 loaded ae at 3", almost_empty, 1);
    do_write(36'h4_0000_0003);
    settle();
    check("R3 loaded ae at 4", almost_empty, 0);
    for (int i = 4; i < DEPTH - 5; i++) begin
      do_write(36'h4_0000_0000 + 36'(i));
      if (i == DEPTH - 7) check("R3 R10 loaded af at free 6", almost_full, 0);
    end
    check("R3 R10 loaded af at free 5", almost_full, 1);
    do_read();
    check("R3 offsets not stored", rd_data, 36'h4_0000_0000);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule